// File: doc/BRIEF.md
# Burst Read Engine with Guaranteed Return Space

This block turns transfer commands into burst reads on a pipelined memory-mapped read master. It then hands the returned words to a downstream consumer as a valid/ready stream. Commands come from a show-ahead command FIFO. Each command carries:

- a byte address
- a byte length
- a flag that selects an advancing or a fixed read address
- a flag that asks for start-of-packet and end-of-packet marks on the output words

The engine works on one command at a time. It splits the command into bursts of at most `MAX_BURST` words and tags each returned word as it arrives. At the end of each command it raises a one-cycle completion pulse that carries the command's byte length.

Returned words land in an internal buffer of `2*MAX_BURST` words. A burst is requested only when that buffer can take the whole burst. The free count is the buffer depth, less the words already stored, less the words still owed by bursts already accepted by memory. Read data therefore never needs a place to wait. Read data is never throttled, and a slow consumer only delays the next request.

Top module: `dmard_read_engine`

## Requirements
- R1: While reset is held and right after it is released, with an empty command FIFO, `cmd_rd`, `mm_read`, `out_valid` and `done_pulse` are all low.
- R2: A command is popped (`cmd_rd` high for exactly one cycle) only while `cmd_empty` is low and no command is in progress. The next pop happens no earlier than the cycle in which the previous command's `done_pulse` is high.
- R3: The first burst of a command uses the command address. With `cmd_incr` = 1, each later burst address equals the previous one plus burstcount × (DATA_W/8). With `cmd_incr` = 0, every burst of the command uses the command address.
- R4: A command of L bytes needs N = ceil(L / (DATA_W/8)) words. Every burst carries `MAX_BURST` words, except the last burst, which carries the remainder. Each burstcount lies between 1 and `MAX_BURST`, and the burstcounts add up to N.
- R5: While `mm_read` is high and `mm_waitrequest` is high, `mm_read`, `mm_address` and `mm_burstcount` stay unchanged in the next cycle.
- R6: Output words appear on `out_data` in the order memory returned them, with no word lost or repeated.
- R7: With `cmd_pkt` = 1, the first word of the command has `out_sop` = 1, the last word has `out_eop` = 1, and every other word has both flags at 0. With `cmd_pkt` = 0, both flags are 0 on every word.
- R8: `done_pulse` is high for one cycle, in the cycle right after the handshake of the command's last word. `done_bytes` then equals the command's byte length L, not rounded to whole words.
- R9: The return buffer holds 2×`MAX_BURST` words. Buffered words plus outstanding words never exceed that depth. With `out_ready` held low, no more than 2×`MAX_BURST` words are ever requested.
- R10: A command of length 0 issues no read and produces no output word. Its `done_pulse` comes in the second cycle after the pop cycle, with `done_bytes` = 0.
- R11: Once `out_valid` is high while `out_ready` is low, `out_valid` and `out_data` stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_empty | input | 1 | Command FIFO has no entry |
| cmd_addr | input | ADDR_W | Byte address of the head command |
| cmd_len | input | LEN_W | Byte length of the head command |
| cmd_incr | input | 1 | Head command advances the read address |
| cmd_pkt | input | 1 | Head command asks for packet marks |
| cmd_rd | output | 1 | Pops the head command |
| mm_read | output | 1 | Burst read request |
| mm_address | output | ADDR_W | Burst byte address |
| mm_burstcount | output | BURST_W | Words in the burst |
| mm_waitrequest | input | 1 | Memory stalls the request |
| mm_readdata | input | DATA_W | Returned word |
| mm_readdatavalid | input | 1 | Returned word is valid |
| out_data | output | DATA_W | Stream data |
| out_valid | output | 1 | Stream word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_sop | output | 1 | First word of a marked command |
| out_eop | output | 1 | Last word of a marked command |
| done_pulse | output | 1 | Command finished |
| done_bytes | output | LEN_W | Byte length of the finished command |

## Verification
The first burst request of a command appears in the cycle after the pop. A returned word can leave the stream in the cycle after its `mm_readdatavalid`. The completion pulse follows the last word's handshake by exactly one cycle, or follows the pop by two cycles for an empty command. The bench samples every port on the falling edge, so it sees the values that the next rising edge will act on. It tags each logged handshake, pop and completion with its cycle number and compares those numbers against the offsets stated here. Burst addresses, burstcounts, stream words and marks are compared against lists computed from the command alone. A held-back consumer shows the request ceiling as the sum of accepted burstcounts after a long wait.

// File: rtl/dmard_pkg.sv
package dmard_pkg;

  // Sequencer phases: waiting for a command, requesting bursts,
  // waiting for the last word of the command to leave the stream.
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_ISSUE = 2'd1,
    RD_DRAIN = 2'd2
  } rd_state_e;

  // Bit positions of the side flags stored next to each data word.
  localparam int TAG_SOP  = 0;
  localparam int TAG_EOP  = 1;
  localparam int TAG_LAST = 2;
  localparam int TAG_W    = 3;

endpackage

// File: rtl/dmard_retbuf.sv
module dmard_retbuf #(
  parameter int WIDTH = 35,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             not_empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_wr, do_rd;

  assign do_wr = wr_en;
  assign do_rd = rd_en && (cnt_q != '0);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_wr) begin
      wr_ptr_d = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
    end
    if (do_rd) begin
      rd_ptr_d = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({do_wr, do_rd})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Storage array carries no reset; only written slots are ever read.
  always_ff @(posedge clk) begin
    if (do_wr) begin
      mem_q[wr_ptr_q] <= wr_data;
    end
  end

  assign rd_data   = mem_q[rd_ptr_q];
  assign not_empty = (cnt_q != '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign count     = cnt_q;

endmodule

// File: rtl/dmard_credit.sv
module dmard_credit #(
  parameter int DEPTH   = 16,
  parameter int BURST_W = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_fire,
  input  logic [BURST_W-1:0] issue_len,
  input  logic               beat_in,
  input  logic [CNT_W-1:0]   stored,
  output logic [CNT_W-1:0]   owed,
  output logic [CNT_W-1:0]   free_words
);

  logic [CNT_W-1:0] owed_q, owed_d;
  logic [CNT_W-1:0] add_w;
  logic [CNT_W-1:0] sub_w;

  assign add_w = issue_fire ? CNT_W'(issue_len) : '0;
  assign sub_w = beat_in ? CNT_W'(1) : '0;

  always_comb begin
    owed_d = owed_q + add_w - sub_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q <= '0;
    end else begin
      owed_q <= owed_d;
    end
  end

  assign owed       = owed_q;
  assign free_words = CNT_W'(DEPTH) - stored - owed_q;

endmodule

// File: rtl/dmard_tagger.sv
module dmard_tagger #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_words,
  input  logic             load_pkt,
  input  logic             beat_in,
  output logic             tag_sop,
  output logic             tag_eop,
  output logic             tag_last
);

  logic [LEN_W-1:0] seen_q, seen_d;
  logic [LEN_W-1:0] total_q, total_d;
  logic             pkt_q, pkt_d;
  logic             at_end;

  always_comb begin
    seen_d  = seen_q;
    total_d = total_q;
    pkt_d   = pkt_q;
    if (load) begin
      seen_d  = '0;
      total_d = load_words;
      pkt_d   = load_pkt;
    end else if (beat_in) begin
      seen_d = seen_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= '0;
      total_q <= '0;
      pkt_q   <= 1'b0;
    end else begin
      seen_q  <= seen_d;
      total_q <= total_d;
      pkt_q   <= pkt_d;
    end
  end

  assign at_end   = (seen_q == total_q - 1'b1);
  assign tag_sop  = pkt_q && (seen_q == '0);
  assign tag_eop  = pkt_q && at_end;
  assign tag_last = at_end;

endmodule

// File: rtl/dmard_issue.sv
module dmard_issue
  import dmard_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 8,
  parameter int BYTES     = 4,
  parameter int BURST_W   = 4,
  parameter int CNT_W     = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_empty,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [LEN_W-1:0]   cmd_len,
  input  logic               cmd_incr,
  input  logic [CNT_W-1:0]   free_words,
  input  logic               mm_waitrequest,
  input  logic               last_out,
  output logic               cmd_rd,
  output logic [LEN_W-1:0]   load_words,
  output logic               mm_read,
  output logic [ADDR_W-1:0]  mm_address,
  output logic [BURST_W-1:0] mm_burstcount,
  output logic               fire,
  output logic               done_pulse,
  output logic [LEN_W-1:0]   done_bytes
);

  localparam int SHIFT = $clog2(BYTES);
  localparam logic [LEN_W-1:0] MAXB_L = LEN_W'(MAX_BURST);

  rd_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              incr_q, incr_d;
  logic              done_q, done_d;
  logic [LEN_W:0]    len_round;
  logic [BURST_W-1:0] burst_sel;
  logic              room;

  // Whole words covered by the head command, rounded up.
  assign len_round  = {1'b0, cmd_len} + (LEN_W + 1)'(BYTES - 1);
  assign load_words = LEN_W'(len_round >> SHIFT);

  assign burst_sel = (left_q > MAXB_L) ? BURST_W'(MAX_BURST) : BURST_W'(left_q);
  assign room      = (free_words >= CNT_W'(burst_sel));

  assign cmd_rd  = (state_q == RD_IDLE) && !cmd_empty;
  assign mm_read = (state_q == RD_ISSUE) && (left_q != '0) && room;
  assign fire    = mm_read && !mm_waitrequest;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    left_d  = left_q;
    len_d   = len_q;
    incr_d  = incr_q;
    done_d  = 1'b0;
    case (state_q)
      RD_IDLE: begin
        if (cmd_rd) begin
          addr_d  = cmd_addr;
          left_d  = load_words;
          len_d   = cmd_len;
          incr_d  = cmd_incr;
          state_d = RD_ISSUE;
        end
      end
      RD_ISSUE: begin
        if (left_q == '0) begin
          done_d  = 1'b1;
          state_d = RD_IDLE;
        end else if (fire) begin
          left_d = left_q - LEN_W'(burst_sel);
          if (incr_q) begin
            addr_d = addr_q + (ADDR_W'(burst_sel) << SHIFT);
          end
          if (left_q == LEN_W'(burst_sel)) begin
            state_d = RD_DRAIN;
          end
        end
      end
      RD_DRAIN: begin
        if (last_out) begin
          done_d  = 1'b1;
          state_d = RD_IDLE;
        end
      end
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      len_q   <= '0;
      incr_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      left_q  <= left_d;
      len_q   <= len_d;
      incr_q  <= incr_d;
      done_q  <= done_d;
    end
  end

  assign mm_address    = addr_q;
  assign mm_burstcount = burst_sel;
  assign done_pulse    = done_q;
  assign done_bytes    = len_q;

endmodule

// File: rtl/dmard_read_engine.sv
module dmard_read_engine
  import dmard_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 8,
  localparam int BURST_W  = $clog2(MAX_BURST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_empty,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [LEN_W-1:0]   cmd_len,
  input  logic               cmd_incr,
  input  logic               cmd_pkt,
  output logic               cmd_rd,
  output logic               mm_read,
  output logic [ADDR_W-1:0]  mm_address,
  output logic [BURST_W-1:0] mm_burstcount,
  input  logic               mm_waitrequest,
  input  logic [DATA_W-1:0]  mm_readdata,
  input  logic               mm_readdatavalid,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_sop,
  output logic               out_eop,
  output logic               done_pulse,
  output logic [LEN_W-1:0]   done_bytes
);

  localparam int BYTES  = DATA_W / 8;
  localparam int DEPTH  = 2 * MAX_BURST;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int ENTRY_W = DATA_W + TAG_W;

  logic [CNT_W-1:0]   buf_count;
  logic [CNT_W-1:0]   outstanding;
  logic [CNT_W-1:0]   free_words;
  logic               buf_full;
  logic               buf_wr;
  logic               buf_rd;
  logic [ENTRY_W-1:0] wr_entry;
  logic [ENTRY_W-1:0] rd_entry;
  logic               issue_fire;
  logic [LEN_W-1:0]   load_words;
  logic               tag_sop, tag_eop, tag_last;
  logic               last_out;

  dmard_issue #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BURST(MAX_BURST),
    .BYTES(BYTES), .BURST_W(BURST_W), .CNT_W(CNT_W)
  ) u_issue (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_empty      (cmd_empty),
    .cmd_addr       (cmd_addr),
    .cmd_len        (cmd_len),
    .cmd_incr       (cmd_incr),
    .free_words     (free_words),
    .mm_waitrequest (mm_waitrequest),
    .last_out       (last_out),
    .cmd_rd         (cmd_rd),
    .load_words     (load_words),
    .mm_read        (mm_read),
    .mm_address     (mm_address),
    .mm_burstcount  (mm_burstcount),
    .fire           (issue_fire),
    .done_pulse     (done_pulse),
    .done_bytes     (done_bytes)
  );

  dmard_credit #(
    .DEPTH(DEPTH), .BURST_W(BURST_W)
  ) u_credit (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_fire (issue_fire),
    .issue_len  (mm_burstcount),
    .beat_in    (mm_readdatavalid),
    .stored     (buf_count),
    .owed       (outstanding),
    .free_words (free_words)
  );

  dmard_tagger #(
    .LEN_W(LEN_W)
  ) u_tagger (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cmd_rd),
    .load_words (load_words),
    .load_pkt   (cmd_pkt),
    .beat_in    (mm_readdatavalid),
    .tag_sop    (tag_sop),
    .tag_eop    (tag_eop),
    .tag_last   (tag_last)
  );

  assign buf_wr = mm_readdatavalid;
  always_comb begin
    wr_entry                   = '0;
    wr_entry[DATA_W-1:0]       = mm_readdata;
    wr_entry[DATA_W + TAG_SOP]  = tag_sop;
    wr_entry[DATA_W + TAG_EOP]  = tag_eop;
    wr_entry[DATA_W + TAG_LAST] = tag_last;
  end

  dmard_retbuf #(
    .WIDTH(ENTRY_W), .DEPTH(DEPTH)
  ) u_retbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (buf_wr),
    .wr_data   (wr_entry),
    .rd_en     (buf_rd),
    .rd_data   (rd_entry),
    .not_empty (out_valid),
    .full      (buf_full),
    .count     (buf_count)
  );

  assign buf_rd   = out_valid && out_ready;
  assign out_data = rd_entry[DATA_W-1:0];
  assign out_sop  = rd_entry[DATA_W + TAG_SOP];
  assign out_eop  = rd_entry[DATA_W + TAG_EOP];
  assign last_out = buf_rd && rd_entry[DATA_W + TAG_LAST];

endmodule

// File: rtl/dmard_read_engine_chk.sv
module dmard_read_engine_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BURST = 8,
  parameter int BURST_W   = 4,
  parameter int CNT_W     = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_empty,
  input logic               cmd_rd,
  input logic               mm_read,
  input logic               mm_waitrequest,
  input logic [ADDR_W-1:0]  mm_address,
  input logic [BURST_W-1:0] mm_burstcount,
  input logic               out_valid,
  input logic               out_ready,
  input logic [DATA_W-1:0]  out_data,
  input logic [CNT_W-1:0]   buf_count,
  input logic [CNT_W-1:0]   outstanding,
  input logic               buf_full,
  input logic               buf_wr
);

  localparam int DEPTH = 2 * MAX_BURST;

  // R2: a pop needs a command present
  a_r2_pop_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd |-> !cmd_empty);

  // R2: pops are single-cycle
  a_r2_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd |=> !cmd_rd);

  // R4: burst length bounds
  a_r4_burst_range: assert property (@(posedge clk) disable iff (!rst_n)
    mm_read |-> (mm_burstcount != '0) && (mm_burstcount <= BURST_W'(MAX_BURST)));

  // R5: stalled request holds
  a_r5_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_read && mm_waitrequest) |=> (mm_read && $stable(mm_address) && $stable(mm_burstcount)));

  // R9: stored plus owed words fit the buffer
  a_r9_no_overcommit: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(buf_count) + 32'(outstanding)) <= DEPTH);

  // R9: no word arrives into a full buffer
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_wr && buf_full));

  // R11: offered word holds until taken
  a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind dmard_read_engine dmard_read_engine_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BURST(MAX_BURST),
  .BURST_W(BURST_W), .CNT_W(CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_empty      (cmd_empty),
  .cmd_rd         (cmd_rd),
  .mm_read        (mm_read),
  .mm_waitrequest (mm_waitrequest),
  .mm_address     (mm_address),
  .mm_burstcount  (mm_burstcount),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_data       (out_data),
  .buf_count      (buf_count),
  .outstanding    (outstanding),
  .buf_full       (buf_full),
  .buf_wr         (buf_wr)
);

// File: tb/test_dmard_read_engine.sv
`timescale 1ns/1ps
module test_dmard_read_engine;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 16;
  localparam int MAXB   = 8;
  localparam int BW     = $clog2(MAXB + 1);
  localparam int BYTES  = DATA_W / 8;
  localparam int LOGN   = 64;

  logic clk;
  logic rst_n;
  logic cmd_empty, cmd_incr, cmd_pkt, cmd_rd;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LEN_W-1:0]  cmd_len;
  logic mm_read, mm_waitrequest, mm_readdatavalid;
  logic [ADDR_W-1:0] mm_address;
  logic [BW-1:0]     mm_burstcount;
  logic [DATA_W-1:0] mm_readdata;
  logic [DATA_W-1:0] out_data;
  logic out_valid, out_ready, out_sop, out_eop, done_pulse;
  logic [LEN_W-1:0] done_bytes;

  int n_chk = 0;
  int n_bad = 0;

  // command queue model (show-ahead)
  logic [ADDR_W-1:0] cq_addr [16];
  logic [LEN_W-1:0]  cq_len  [16];
  logic              cq_incr [16];
  logic              cq_pkt  [16];
  int cq_wr = 0;
  int cq_rd = 0;

  assign cmd_empty = (cq_rd == cq_wr);
  assign cmd_addr  = cq_addr[cq_rd % 16];
  assign cmd_len   = cq_len[cq_rd % 16];
  assign cmd_incr  = cq_incr[cq_rd % 16];
  assign cmd_pkt   = cq_pkt[cq_rd % 16];

  // logs
  int b_addr [LOGN]; int b_cnt [LOGN]; int nb = 0;
  logic [DATA_W-1:0] w_data [LOGN]; logic w_sop [LOGN]; logic w_eop [LOGN];
  int hs_cyc [LOGN]; int nw = 0;
  int d_cyc [8]; int d_bytes [8]; int nd = 0;
  int p_cyc [8]; int np = 0;
  int cyc = 0;

  // memory model
  logic [ADDR_W-1:0] pend [256];
  int ph = 0;
  int pt = 0;
  bit wr_toggle = 0;
  bit ret_gap = 0;
  bit rdy_hold = 0;
  bit rdy_toggle = 0;

  dmard_read_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .MAX_BURST(MAXB)
  ) i_dmard_read_engine (
    .clk(clk), .rst_n(rst_n),
    .cmd_empty(cmd_empty), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_incr(cmd_incr), .cmd_pkt(cmd_pkt), .cmd_rd(cmd_rd),
    .mm_read(mm_read), .mm_address(mm_address), .mm_burstcount(mm_burstcount),
    .mm_waitrequest(mm_waitrequest), .mm_readdata(mm_readdata),
    .mm_readdatavalid(mm_readdatavalid),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_sop(out_sop), .out_eop(out_eop),
    .done_pulse(done_pulse), .done_bytes(done_bytes)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  function automatic logic [DATA_W-1:0] fmem(logic [ADDR_W-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h0000_55AA;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // environment: sample at falling edge, drive just after rising edge
  initial begin
    mm_waitrequest = 1'b0;
    mm_readdatavalid = 1'b0;
    mm_readdata = '0;
    out_ready = 1'b1;
    forever begin
      bit popnow;
      @(negedge clk);
      popnow = 0;
      cyc++;
      if (rst_n) begin
        if (mm_read && !mm_waitrequest) begin
          if (nb < LOGN) begin
            b_addr[nb] = int'(mm_address);
            b_cnt[nb] = int'(mm_burstcount);
          end
          nb++;
          for (int k = 0; k < int'(mm_burstcount); k++) begin
            pend[pt % 256] = mm_address + ADDR_W'(k * BYTES);
            pt++;
          end
        end
        if (out_valid && out_ready) begin
          if (nw < LOGN) begin
            w_data[nw] = out_data; w_sop[nw] = out_sop;
            w_eop[nw] = out_eop; hs_cyc[nw] = cyc;
          end
          nw++;
        end
        if (done_pulse) begin
          if (nd < 8) begin d_cyc[nd] = cyc; d_bytes[nd] = int'(done_bytes); end
          nd++;
        end
        if (cmd_rd) begin
          if (np < 8) p_cyc[np] = cyc;
          np++;
          popnow = 1;
        end
      end
      @(posedge clk);
      #1;
      if (popnow) cq_rd++;
      if (ph != pt && !(ret_gap && (cyc % 3 == 1))) begin
        mm_readdatavalid = 1'b1;
        mm_readdata = fmem(pend[ph % 256]);
        ph++;
      end else begin
        mm_readdatavalid = 1'b0;
      end
      mm_waitrequest = wr_toggle ? (cyc % 3 != 0) : 1'b0;
      out_ready = rdy_hold ? 1'b0 : (rdy_toggle ? cyc[0] : 1'b1);
    end
  end

  task automatic clear_logs();
    nb = 0; nw = 0; nd = 0; np = 0;
  endtask

  task automatic push_cmd(int a, int len, bit incr, bit pkt);
    cq_addr[cq_wr % 16] = ADDR_W'(a);
    cq_len[cq_wr % 16]  = LEN_W'(len);
    cq_incr[cq_wr % 16] = incr;
    cq_pkt[cq_wr % 16]  = pkt;
    cq_wr++;
  endtask

  task automatic wait_done(int count, string req);
    int t = 0;
    while (nd < count && t < 3000) begin
      @(posedge clk); #1; t++;
    end
    check(req, "completion seen", nd >= count, 1);
    repeat (3) @(posedge clk);
    #1;
  endtask

  // compares bursts, words, marks and completion of one logged command
  task automatic verify(string tag, int a, int len, bit incr, bit pkt);
    int n;
    int nbx;
    n = (len + BYTES - 1) / BYTES;
    nbx = (n + MAXB - 1) / MAXB;
    check("R4", {tag, " burst count"}, nb, nbx);
    for (int b = 0; b < nbx && b < nb; b++) begin
      int cnt;
      int ba;
      cnt = (b == nbx - 1) ? n - MAXB * (nbx - 1) : MAXB;
      ba = incr ? a + b * MAXB * BYTES : a;
      check("R4", {tag, " burstcount"}, b_cnt[b], cnt);
      check("R3", {tag, " burst address"}, b_addr[b], ba);
    end
    check("R6", {tag, " word count"}, nw, n);
    for (int w = 0; w < n && w < nw; w++) begin
      int ba;
      ba = incr ? a + (w / MAXB) * MAXB * BYTES : a;
      check("R6", {tag, " data"}, w_data[w], fmem(ADDR_W'(ba + (w % MAXB) * BYTES)));
      check("R7", {tag, " sop"}, w_sop[w], pkt && (w == 0));
      check("R7", {tag, " eop"}, w_eop[w], pkt && (w == n - 1));
    end
    check("R8", {tag, " done count"}, nd, 1);
    check("R8", {tag, " done bytes"}, d_bytes[0], len);
    if (n > 0 && nw >= n) check("R8", {tag, " done timing"}, d_cyc[0], hs_cyc[n - 1] + 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R1", "cmd_rd in reset", cmd_rd, 0);
    check("R1", "mm_read in reset", mm_read, 0);
    check("R1", "out_valid in reset", out_valid, 0);
    check("R1", "done in reset", done_pulse, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "mm_read after reset", mm_read, 0);
    check("R1", "out_valid after reset", out_valid, 0);
    check("R1", "done after reset", done_pulse, 0);
    check("R1", "cmd_rd after reset", cmd_rd, 0);
    @(posedge clk); #1;
  endtask

  task automatic t_single(string tag, int a, int len, bit incr, bit pkt);
    clear_logs();
    push_cmd(a, len, incr, pkt);
    wait_done(1, "R8");
    verify(tag, a, len, incr, pkt);
    check("R2", {tag, " one pop"}, np, 1);
  endtask

  task automatic t_zero_len();
    clear_logs();
    push_cmd(32'h0000_9000, 0, 1, 1);
    wait_done(1, "R10");
    check("R10", "no burst", nb, 0);
    check("R10", "no word", nw, 0);
    check("R10", "bytes zero", d_bytes[0], 0);
    check("R10", "done two cycles after pop", d_cyc[0], p_cyc[0] + 2);
  endtask

  task automatic t_backpressure();
    int sum = 0;
    clear_logs();
    rdy_hold = 1;
    @(posedge clk); #1;
    push_cmd(32'h0000_6000, 200, 1, 1);
    repeat (80) @(posedge clk);
    #1;
    for (int b = 0; b < nb && b < LOGN; b++) sum += b_cnt[b];
    check("R9", "words requested with consumer stalled", sum, 2 * MAXB);
    check("R9", "no word taken while stalled", nw, 0);
    rdy_hold = 0;
    wait_done(1, "R9");
    verify("stall", 32'h0000_6000, 200, 1, 1);
  endtask

  task automatic t_back_to_back();
    clear_logs();
    push_cmd(32'h0000_7000, 24, 1, 1);
    push_cmd(32'h0000_8000, 12, 1, 1);
    wait_done(2, "R2");
    check("R2", "two pops", np, 2);
    check("R2", "second pop not before first done", p_cyc[1] >= d_cyc[0], 1);
    check("R6", "total words", nw, 9);
    check("R7", "second command sop", w_sop[6], 1);
    check("R7", "first command eop", w_eop[5], 1);
    check("R8", "second done bytes", d_bytes[1], 12);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_single("short", 32'h0000_1000, 20, 1, 1);
    wr_toggle = 1;
    t_single("split", 32'h0000_2000, 100, 1, 1);
    wr_toggle = 0;
    t_single("fixed", 32'h0000_3000, 64, 0, 1);
    rdy_toggle = 1; ret_gap = 1;
    t_single("unmarked", 32'h0000_4000, 36, 1, 0);
    rdy_toggle = 0; ret_gap = 0;
    t_single("odd", 32'h0000_5000, 10, 1, 1);
    t_zero_len();
    t_backpressure();
    t_back_to_back();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (R1-level run) actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule